// File: doc/BRIEF.md
# Golomb Run-Length Bitstream Encoder

This block compresses a serial stream of binary data. It treats the stream as a series of zero-runs, each ended by a one. For every run it counts the zeros and sends out one Golomb codeword for that count. The codeword is built around a divisor `M` that is fixed when the block is elaborated. The count divided by `M` goes out in unary. The leftover count goes out in truncated binary, which keeps the code prefix-free for any `M` of two or more.

Input bits arrive one per cycle under a valid/ready handshake. Code bits leave one per cycle on a second valid/ready handshake. While a codeword is still being sent, no new input is accepted. An end-of-stream flag travels with the last input bit. If that bit is a zero, the final run is closed as though a one had followed it, so the decoder can recover every bit.

The run counter has a fixed width. A run longer than the counter can hold is reported on a sticky overflow flag and is otherwise not supported.

Top module: `golomb_rle_enc`

## Requirements
- R1: Each accepted 1 closes a run whose length N is the number of zeros accepted since the previous close (N may be 0), and produces exactly one codeword. An accepted 0 without the end flag produces no output bit.
- R2: Each codeword starts with floor(N/M) zero bits followed by a single 1 stop bit.
- R3: When M is a power of two, the stop bit is followed by N mod M in log2(M) bits, most significant bit first (M=4, N=15 gives 000111; M=8, N=61 gives 00000001101).
- R4: When M is not a power of two, let b = ceil(log2 M) and u = 2^b − M. A remainder r < u is sent as r in b−1 bits; otherwise r+u is sent in b bits, most significant bit first (M=5: r=0..2 give 00,01,10 and r=3,4 give 110,111).
- R5: When an input is accepted with in_last high and in_bit 0, the current run is closed with length N+1, where N is the count before that zero. With in_bit 1 the run closes normally. In both cases the next run starts from zero.
- R6: in_ready is low whenever out_valid is high. While out_valid is high and out_ready is low, out_valid and out_bit hold their values.
- R7: A zero accepted while the run count equals 2^CNT_W−1 sets overflow, which stays high until reset. Runs up to 2^CNT_W−1 zeros do not set it.
- R8: After reset, out_valid is 0, in_ready is 1 and overflow is 0.
- R9: in_bit and in_last have no effect in cycles where in_valid is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input bit is present |
| in_bit | input | 1 | Data bit of the stream |
| in_last | input | 1 | This bit is the final one of the stream |
| in_ready | output | 1 | Block accepts an input bit this cycle |
| out_valid | output | 1 | out_bit holds a code bit |
| out_bit | output | 1 | Current code bit |
| out_ready | input | 1 | Consumer takes the code bit this cycle |
| overflow | output | 1 | Sticky flag: a run exceeded the counter |

## Verification
The bench builds four encoders side by side, with M = 2, 4, 5 and 8, each with an 8-bit run counter. M=2 is the default, with a one-bit remainder. M=4 and M=8 use plain-binary remainders and reproduce the worked examples for N=15 and N=61. M=5 reaches both the short and the long truncated-binary forms. The narrow counter puts the saturation boundary and the overflow flag within a few hundred cycles, and a run of exactly 255 zeros checks the largest codeword that is still legal.

// File: rtl/golomb_enc_pkg.sv
package golomb_enc_pkg;

  typedef enum logic [1:0] {
    PH_IDLE,
    PH_UNARY,
    PH_STOP,
    PH_REM
  } emit_phase_t;

  // Number of remainder bits for divisor m (m >= 2 assumed).
  function automatic int rem_bits(input int m);
    return (m < 2) ? 1 : $clog2(m);
  endfunction

  // Width of a field holding a remainder length 0..rem_bits(m).
  function automatic int len_bits(input int m);
    return $clog2(rem_bits(m) + 1);
  endfunction

  function automatic bit is_pow2(input int m);
    return (m > 0) && ((m & (m - 1)) == 0);
  endfunction

endpackage

// File: rtl/golomb_run_tracker.sv
module golomb_run_tracker #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             take,
  input  logic             din,
  input  logic             last_in,
  output logic             close,
  output logic [CNT_W-1:0] run_len,
  output logic             overflow
);

  localparam logic [CNT_W-1:0] CNT_MAX = '1;
  localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q;
  logic             ovf_q;
  logic             at_max;

  assign at_max = (cnt_q == CNT_MAX);

  // A one ends the run; the end flag ends it too, counting a final zero.
  assign close = take && (din || last_in);

  always_comb begin
    if (din) begin
      run_len = cnt_q;
    end else if (at_max) begin
      run_len = CNT_MAX;
    end else begin
      run_len = cnt_q + CNT_ONE;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      ovf_q <= 1'b0;
    end else if (take) begin
      if (close) begin
        cnt_q <= '0;
      end else if (!at_max) begin
        cnt_q <= cnt_q + CNT_ONE;
      end
      if (!din && at_max) begin
        ovf_q <= 1'b1;
      end
    end
  end

  assign overflow = ovf_q;

endmodule

// File: rtl/golomb_code_map.sv
module golomb_code_map
  import golomb_enc_pkg::*;
#(
  parameter int M   = 2,
  parameter int N_W = 16
) (
  input  logic [N_W-1:0]          n,
  output logic [N_W-1:0]          q,
  output logic [rem_bits(M)-1:0]  code,
  output logic [len_bits(M)-1:0]  len
);

  localparam int B  = rem_bits(M);
  localparam int LW = len_bits(M);
  localparam int U  = (1 << B) - M;

  generate
    if (is_pow2(M)) begin : g_pow2
      // Divisor is a power of two: quotient is a shift, remainder a slice.
      assign q    = n >> B;
      assign code = n[B-1:0];
      assign len  = LW'(B);
    end else begin : g_trunc
      localparam logic [N_W-1:0] M_N = N_W'(M);
      localparam logic [B-1:0]   U_B = B'(U);
      logic [B-1:0] r;

      assign q = n / M_N;
      assign r = B'(n % M_N);

      always_comb begin
        if (r < U_B) begin
          code = r;
          len  = LW'(B - 1);
        end else begin
          code = r + U_B;
          len  = LW'(B);
        end
      end
    end
  endgenerate

endmodule

// File: rtl/golomb_bit_emitter.sv
module golomb_bit_emitter
  import golomb_enc_pkg::*;
#(
  parameter int Q_W = 16,
  parameter int B   = 1,
  parameter int LW  = 1
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           load,
  input  logic [Q_W-1:0] q,
  input  logic [B-1:0]   code,
  input  logic [LW-1:0]  len,
  input  logic           out_ready,
  output logic           out_valid,
  output logic           out_bit,
  output logic           in_ready
);

  localparam logic [Q_W-1:0] Q_ONE = Q_W'(1);
  localparam logic [LW-1:0]  L_ONE = LW'(1);

  emit_phase_t   ph_q, ph_d;
  logic [Q_W-1:0] zl_q, zl_d;
  logic [LW-1:0]  rl_q, rl_d;
  logic [B-1:0]   code_q, code_d;
  logic           bit_q, bit_d;
  logic           vld_q, rdy_q;
  logic [LW-1:0]  idx;
  logic [B-1:0]   shifted;

  assign idx     = rl_q - L_ONE;
  assign shifted = code_q >> idx;

  always_comb begin
    ph_d   = ph_q;
    zl_d   = zl_q;
    rl_d   = rl_q;
    code_d = code_q;
    bit_d  = bit_q;
    if (load) begin
      code_d = code;
      rl_d   = len;
      if (q != '0) begin
        ph_d  = PH_UNARY;
        zl_d  = q - Q_ONE;
        bit_d = 1'b0;
      end else begin
        ph_d  = PH_STOP;
        zl_d  = '0;
        bit_d = 1'b1;
      end
    end else if (vld_q && out_ready) begin
      unique case (ph_q)
        PH_UNARY: begin
          if (zl_q != '0) begin
            zl_d  = zl_q - Q_ONE;
            bit_d = 1'b0;
          end else begin
            ph_d  = PH_STOP;
            bit_d = 1'b1;
          end
        end
        PH_STOP, PH_REM: begin
          if (rl_q != '0) begin
            ph_d  = PH_REM;
            bit_d = shifted[0];
            rl_d  = idx;
          end else begin
            ph_d  = PH_IDLE;
            bit_d = 1'b0;
          end
        end
        default: ph_d = PH_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ph_q   <= PH_IDLE;
      zl_q   <= '0;
      rl_q   <= '0;
      code_q <= '0;
      bit_q  <= 1'b0;
      vld_q  <= 1'b0;
      rdy_q  <= 1'b1;
    end else begin
      ph_q   <= ph_d;
      zl_q   <= zl_d;
      rl_q   <= rl_d;
      code_q <= code_d;
      bit_q  <= bit_d;
      vld_q  <= (ph_d != PH_IDLE);
      rdy_q  <= (ph_d == PH_IDLE);
    end
  end

  assign out_valid = vld_q;
  assign out_bit   = bit_q;
  assign in_ready  = rdy_q;

endmodule

// File: rtl/golomb_rle_enc.sv
module golomb_rle_enc
  import golomb_enc_pkg::*;
#(
  parameter int M     = 2,
  parameter int CNT_W = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic in_valid,
  input  logic in_bit,
  input  logic in_last,
  output logic in_ready,
  output logic out_valid,
  output logic out_bit,
  input  logic out_ready,
  output logic overflow
);

  localparam int B  = rem_bits(M);
  localparam int LW = len_bits(M);

  logic             take;
  logic             close;
  logic [CNT_W-1:0] run_len;
  logic [CNT_W-1:0] quo;
  logic [B-1:0]     rcode;
  logic [LW-1:0]    rlen;

  assign take = in_valid && in_ready;

  golomb_run_tracker #(.CNT_W(CNT_W)) u_track (
    .clk      (clk),
    .rst      (rst),
    .take     (take),
    .din      (in_bit),
    .last_in  (in_last),
    .close    (close),
    .run_len  (run_len),
    .overflow (overflow)
  );

  golomb_code_map #(.M(M), .N_W(CNT_W)) u_map (
    .n    (run_len),
    .q    (quo),
    .code (rcode),
    .len  (rlen)
  );

  golomb_bit_emitter #(.Q_W(CNT_W), .B(B), .LW(LW)) u_emit (
    .clk       (clk),
    .rst       (rst),
    .load      (close),
    .q         (quo),
    .code      (rcode),
    .len       (rlen),
    .out_ready (out_ready),
    .out_valid (out_valid),
    .out_bit   (out_bit),
    .in_ready  (in_ready)
  );

endmodule

// File: rtl/golomb_rle_enc_chk.sv
module golomb_rle_enc_chk (
  input logic clk,
  input logic rst,
  input logic in_valid,
  input logic in_bit,
  input logic in_last,
  input logic in_ready,
  input logic out_valid,
  input logic out_bit,
  input logic out_ready,
  input logic overflow
);

  // R6: no input accepted while a codeword is in flight
  assert_ready_excl_R6: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> !in_ready);

  // R6: stalled code bit is held
  assert_hold_R6: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_bit)));

  // R1: an accepted one starts a codeword
  assert_close_emits_R1: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready && in_bit) |=> out_valid);

  // R1: an accepted plain zero emits nothing
  assert_zero_silent_R1: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready && !in_bit && !in_last) |=> !out_valid);

  // R5: end-of-stream always closes the run
  assert_eos_emits_R5: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready && in_last) |=> out_valid);

  // R7: overflow is sticky
  assert_ovf_sticky_R7: assert property (@(posedge clk) disable iff (rst)
    overflow |=> overflow);

endmodule

bind golomb_rle_enc golomb_rle_enc_chk u_chk (
  .clk       (clk),
  .rst       (rst),
  .in_valid  (in_valid),
  .in_bit    (in_bit),
  .in_last   (in_last),
  .in_ready  (in_ready),
  .out_valid (out_valid),
  .out_bit   (out_bit),
  .out_ready (out_ready),
  .overflow  (overflow)
);

// File: tb/golomb_rle_enc_tb_top.sv
module golomb_lane_tb #(
  parameter int          M     = 2,
  parameter int          CNT_W = 8,
  parameter int unsigned SEED  = 1
) (
  input  logic clk,
  input  logic rst,
  output logic done
);

  int   errs = 0;
  int   checks = 0;
  logic in_valid = 1'b0, in_bit = 1'b0, in_last = 1'b0, out_ready = 1'b0;
  logic in_ready, out_valid, out_bit, overflow;

  golomb_rle_enc #(.M(M), .CNT_W(CNT_W)) dut_i (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_bit(in_bit),
    .in_last(in_last), .in_ready(in_ready), .out_valid(out_valid),
    .out_bit(out_bit), .out_ready(out_ready), .overflow(overflow)
  );

  bit   exp_q[$];
  int   tag_q[$];
  int   mcnt = 0;
  logic prev_stall = 1'b0;
  logic prev_bit = 1'b0;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s M=%0d %s: actual %0d expected %0d", req, M, what, act, exp);
    end
  endtask

  function automatic string req_name(input int t);
    case (t)
      2: return "R2";
      3: return "R3";
      4: return "R4";
      5: return "R5";
      default: return "R1";
    endcase
  endfunction

  // Expected codeword from the requirement text (R2, R3, R4, R5 tags).
  task automatic push_code(input int n, input bit eos);
    int q, r, b, u, val, nb, rtag;
    q = n / M;
    r = n % M;
    b = $clog2(M);
    u = (1 << b) - M;
    for (int i = 0; i < q; i++) begin
      exp_q.push_back(1'b0);
      tag_q.push_back(eos ? 5 : 2);
    end
    exp_q.push_back(1'b1);
    tag_q.push_back(eos ? 5 : 2);
    if (u == 0) begin
      val = r; nb = b;
    end else if (r < u) begin
      val = r; nb = b - 1;
    end else begin
      val = r + u; nb = b;
    end
    rtag = eos ? 5 : ((u == 0) ? 3 : 4);
    for (int i = nb - 1; i >= 0; i--) begin
      exp_q.push_back(bit'((val >> i) & 1));
      tag_q.push_back(rtag);
    end
  endtask

  task automatic model_take(input logic b, input logic l);
    if (b) begin
      push_code(mcnt, l);
      mcnt = 0;
    end else if (l) begin
      push_code(mcnt + 1, 1'b1);
      mcnt = 0;
    end else begin
      mcnt++;
    end
  endtask

  task automatic tick(input logic v, input logic b, input logic l, output bit acc);
    bit e;
    int t;
    @(negedge clk);
    in_valid  = v;
    in_bit    = b;
    in_last   = l;
    out_ready = (($urandom % 10) < 7);
    #1;
    if (prev_stall)
      chk(out_valid === 1'b1 && out_bit === prev_bit, "R6", "held bit under stall",
          int'(out_bit), int'(prev_bit));
    if (out_valid === 1'b1)
      chk(in_ready === 1'b0, "R6", "in_ready while draining", int'(in_ready), 0);
    if (out_valid === 1'b1 && out_ready) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, "R1", "unexpected code bit", int'(out_bit), -1);
      end else begin
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        chk(out_bit === e, req_name(t), "code bit", int'(out_bit), int'(e));
      end
    end
    prev_stall = (out_valid === 1'b1) && !out_ready;
    prev_bit   = out_bit;
    acc = v && (in_ready === 1'b1);
    if (acc) model_take(b, l);
  endtask

  // Idle cycles drive random in_bit to exercise R9.
  task automatic send(input logic b, input logic l);
    bit acc, v;
    do begin
      v = (($urandom % 4) != 0);
      tick(v, v ? b : 1'($urandom), v ? l : 1'b0, acc);
    end while (!acc);
  endtask

  task automatic drain();
    bit acc;
    int guard = 0;
    do begin
      tick(1'b0, 1'b0, 1'b0, acc);
      guard++;
    end while ((exp_q.size() != 0 || out_valid === 1'b1) && guard < 5000);
  endtask

  task automatic run(input int nz, input logic b, input logic l);
    for (int i = 0; i < nz; i++) send(1'b0, 1'b0);
    send(b, l);
  endtask

  initial begin
    bit acc;
    done = 1'b0;
    void'($urandom(SEED));
    @(negedge clk);
    @(negedge clk);
    // R8: reset state
    chk(out_valid === 1'b0, "R8", "out_valid in reset", int'(out_valid), 0);
    chk(in_ready === 1'b1, "R8", "in_ready in reset", int'(in_ready), 1);
    chk(overflow === 1'b0, "R8", "overflow in reset", int'(overflow), 0);
    while (rst !== 1'b0) @(negedge clk);

    // R1/R2: every run length from 0 up to past two quotient steps
    for (int n = 0; n <= 2 * M + 2; n++) run(n, 1'b1, 1'b0);
    drain();

    // R5: end flag on a zero, on a lone zero, on a one, then a fresh run
    run(2, 1'b0, 1'b1);
    run(0, 1'b0, 1'b1);
    run(4, 1'b1, 1'b1);
    run(1, 1'b1, 1'b0);
    drain();

    // R3: worked examples
    run(15, 1'b1, 1'b0);
    run(61, 1'b1, 1'b0);
    drain();

    // Random traffic, R9 via idle cycles inside send
    for (int i = 0; i < 400; i++) begin
      logic b, l;
      b = (($urandom % 3) == 0);
      l = b ? 1'b0 : (($urandom % 25) == 0);
      send(b, l);
    end
    send(1'b1, 1'b0);
    drain();

    // R7: longest legal run, no flag
    run((1 << CNT_W) - 1, 1'b1, 1'b0);
    drain();
    chk(overflow === 1'b0, "R7", "overflow after max legal run", int'(overflow), 0);

    for (int i = 0; i < (1 << CNT_W) - 1; i++) send(1'b0, 1'b0);
    tick(1'b0, 1'b0, 1'b0, acc);
    chk(overflow === 1'b0, "R7", "overflow at count limit", int'(overflow), 0);
    send(1'b0, 1'b0);
    tick(1'b0, 1'b0, 1'b0, acc);
    chk(overflow === 1'b1, "R7", "overflow past limit", int'(overflow), 1);
    for (int i = 0; i < 5; i++) tick(1'b0, 1'b0, 1'b0, acc);
    chk(overflow === 1'b1, "R7", "overflow sticky", int'(overflow), 1);

    chk(exp_q.size() == 0, "R1", "leftover expected bits", exp_q.size(), 0);
    chk(out_valid === 1'b0, "R1", "idle at end", int'(out_valid), 0);
    done = 1'b1;
  end

endmodule

module golomb_rle_enc_tb_top;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic d2, d4, d5, d8;
  bit   timed_out = 1'b0;

  always #5 clk = ~clk;

  golomb_lane_tb #(.M(2), .CNT_W(8), .SEED(11)) l_m2 (.clk(clk), .rst(rst), .done(d2));
  golomb_lane_tb #(.M(4), .CNT_W(8), .SEED(23)) l_m4 (.clk(clk), .rst(rst), .done(d4));
  golomb_lane_tb #(.M(5), .CNT_W(8), .SEED(37)) l_m5 (.clk(clk), .rst(rst), .done(d5));
  golomb_lane_tb #(.M(8), .CNT_W(8), .SEED(41)) l_m8 (.clk(clk), .rst(rst), .done(d8));

  initial begin
    int errs, checks;
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    fork
      wait (d2 === 1'b1 && d4 === 1'b1 && d5 === 1'b1 && d8 === 1'b1);
      begin
        repeat (150000) @(posedge clk);
        timed_out = 1'b1;
      end
    join_any
    errs   = l_m2.errs + l_m4.errs + l_m5.errs + l_m8.errs;
    checks = l_m2.checks + l_m4.checks + l_m5.checks + l_m8.checks;
    if (timed_out) begin
      errs++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
    end
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

endmodule